// File: doc/BRIEF.md
# Arithmetic Status and Control Flags Register

This block sits beside an integer adder/subtractor and keeps the machine's 16-bit flags word. When the update strobe is high, it takes the operands, the result and the adder carry-out of an add or subtract at 8, 16 or 32 bits. From these it derives six status flags: carry, parity, half-carry, zero, sign and overflow. It writes all six into the word in the same cycle. The sign and overflow bit positions follow the operation width. Half-carry and parity always come from the low byte.

The same word holds three control bits: string direction, interrupt enable and single-step trap. Arithmetic never changes them. They change only through their own set and clear strobes or through a full load of the word. A full load writes every defined bit at once and forces the undefined bits to zero. The word is always visible on a read port.

Top module: `alu_flags_reg`

## Requirements
- R1: With update high, the sign flag becomes the most significant bit of the result at the operation width (width code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits).
- R2: With update high, the zero flag becomes 1 exactly when the result bits inside the operation width are all zero. Result bits above the width are ignored.
- R3: With update high, the half-carry flag becomes the carry (add) or borrow (subtract) from bit 3 into bit 4, that is `a[4] ^ b[4] ^ result[4]`.
- R4: With update high, the parity flag becomes 1 when the low 8 result bits hold an odd number of ones, and 0 when they hold an even number.
- R5: The carry flag is set from the adder carry-out, which the adder forms as a + ~b + 1 when subtracting.
  - On an add it takes the carry-out.
  - On a subtract it takes the inverted carry-out, so it means borrow.
- R6: The overflow flag is set on signed overflow at the operation width.
  - Add: both operands have the same sign, and the result's sign differs from it.
  - Subtract: the operand signs differ, and the result's sign differs from the first operand's sign.
- R7: An update changes none of the three control bits. With update and load both low, the six status flags keep their values.
- R8: Each control bit has a set strobe and a clear strobe. When both are high in the same cycle, clear wins. A strobe changes only its own bit.
- R9: A load writes the whole word from the load data, with the undefined bits read back as 0. In the same cycle, a load overrides any update and any set or clear strobe.
- R10: The word layout is carry = bit 0, parity = 2, half-carry = 4, zero = 6, sign = 7, trap = 8, interrupt enable = 9, direction = 10, overflow = 11. All other bits read 0. Reset clears the word to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Write the six status flags from the current operation |
| width_i | input | 2 | Operation width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| sub_i | input | 1 | 1 for subtract, 0 for add |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_i | input | 32 | Adder result; bits above the width are don't-care |
| cout_i | input | 1 | Adder carry out of the top bit at the width |
| ld_i | input | 1 | Load the whole flags word |
| ld_data_i | input | 16 | Value for the load |
| set_i | input | 3 | Set strobes: bit 0 trap, bit 1 interrupt enable, bit 2 direction |
| clr_i | input | 3 | Clear strobes, same bit order as set_i |
| flags_o | output | 16 | Current flags word |

## Verification
The bench drives results with junk above the operation width. A unit that tests zero or sign on the full 32 bits would then report a nonzero or negative result for an 8-bit zero. It crosses the signed boundary in each direction at each width, such as 0x7F + 1 and 0x8000 - 1. Taking the wrong sign bit, or using the add overflow rule on a subtract, would then misreport overflow.

A subtract of 0 - 1 checks that carry means borrow. A block that copies the raw carry-out would leave carry clear. Updates are interleaved with control strobes, so an update that rewrites the whole word would lose the direction, interrupt and trap bits. The bench also raises set and clear together, and raises load together with update and strobes. These cases expose a wrong priority order or undefined bits that leak through on a load.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int unsigned FLAGS_W = 16;
  localparam int unsigned NCTRL   = 3;

  localparam int unsigned BIT_CF = 0;
  localparam int unsigned BIT_PF = 2;
  localparam int unsigned BIT_AF = 4;
  localparam int unsigned BIT_ZF = 6;
  localparam int unsigned BIT_SF = 7;
  localparam int unsigned BIT_TF = 8;   // control bits 8..10 contiguous
  localparam int unsigned BIT_IF = 9;
  localparam int unsigned BIT_DF = 10;
  localparam int unsigned BIT_OF = 11;

  localparam logic [FLAGS_W-1:0] DEF_MASK = 16'h0FD5;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_WIDE = 2'd3
  } op_width_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } stat_t;

endpackage

// File: rtl/alu_flags_calc.sv
module alu_flags_calc
  import alu_flags_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    width_i,
  input  logic          sub_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  output stat_t         stat_o
);

  localparam int unsigned HW = DW / 2;
  localparam int unsigned BW = 8;

  op_width_e w;
  logic      sa, sb, sr;
  logic [DW-1:0] res_m;

  assign w = op_width_e'(width_i);

  always_comb begin
    unique case (w)
      W_BYTE: begin
        sa    = a_i[BW-1];
        sb    = b_i[BW-1];
        sr    = res_i[BW-1];
        res_m = {{(DW-BW){1'b0}}, res_i[BW-1:0]};
      end
      W_HALF: begin
        sa    = a_i[HW-1];
        sb    = b_i[HW-1];
        sr    = res_i[HW-1];
        res_m = {{(DW-HW){1'b0}}, res_i[HW-1:0]};
      end
      default: begin
        sa    = a_i[DW-1];
        sb    = b_i[DW-1];
        sr    = res_i[DW-1];
        res_m = res_i;
      end
    endcase
  end

  always_comb begin
    stat_o.sf_f = sr;
    stat_o.zf_f = (res_m == '0);
    stat_o.af_f = a_i[4] ^ b_i[4] ^ res_i[4];
    stat_o.pf_f = ^res_i[BW-1:0];
    stat_o.cf_f = sub_i ? ~cout_i : cout_i;
    // sub: a - b overflows when signs differ and result flips away from a
    stat_o.of_f = (sub_i ? (sa != sb) : (sa == sb)) && (sr != sa);
  end

endmodule

// File: rtl/alu_flags_ctrl.sv
module alu_flags_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         ld_i,
  input  logic [N-1:0] ld_val_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (ld_i)     q_o[g] <= ld_val_i[g];
      else if (clr_i[g]) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !ld_i) |=> !q_o[g]) else $error("clear lost");   // R8
    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[g] && !clr_i[g] && !ld_i) |=> q_o[g]) else $error("set lost");  // R8
  end

endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
  import alu_flags_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [1:0]    width_i,
  input  logic          sub_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          ld_i,
  input  logic [15:0]   ld_data_i,
  input  logic [2:0]    set_i,
  input  logic [2:0]    clr_i,
  output logic [15:0]   flags_o
);

  stat_t            stat_d, stat_q, stat_ld;
  logic [NCTRL-1:0] ctrl_q;

  alu_flags_calc #(.DW(DW)) u_calc (
    .width_i (width_i),
    .sub_i   (sub_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_i   (res_i),
    .cout_i  (cout_i),
    .stat_o  (stat_d)
  );

  alu_flags_ctrl #(.N(NCTRL)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_i),
    .clr_i    (clr_i),
    .ld_i     (ld_i),
    .ld_val_i (ld_data_i[BIT_DF:BIT_TF]),
    .q_o      (ctrl_q)
  );

  always_comb begin
    stat_ld.of_f = ld_data_i[BIT_OF];
    stat_ld.sf_f = ld_data_i[BIT_SF];
    stat_ld.zf_f = ld_data_i[BIT_ZF];
    stat_ld.af_f = ld_data_i[BIT_AF];
    stat_ld.pf_f = ld_data_i[BIT_PF];
    stat_ld.cf_f = ld_data_i[BIT_CF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (ld_i)  stat_q <= stat_ld;
    else if (upd_i) stat_q <= stat_d;
  end

  always_comb begin
    flags_o                   = '0;
    flags_o[BIT_CF]           = stat_q.cf_f;
    flags_o[BIT_PF]           = stat_q.pf_f;
    flags_o[BIT_AF]           = stat_q.af_f;
    flags_o[BIT_ZF]           = stat_q.zf_f;
    flags_o[BIT_SF]           = stat_q.sf_f;
    flags_o[BIT_DF:BIT_TF]    = ctrl_q;
    flags_o[BIT_OF]           = stat_q.of_f;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~DEF_MASK) == '0) else $error("reserved bit set");   // R10
  AST_LOAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> flags_o == ($past(ld_data_i) & DEF_MASK)) else $error("load");  // R9
  AST_CTRL_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ld_i && set_i == '0 && clr_i == '0) |=> $stable(flags_o[BIT_DF:BIT_TF]))
    else $error("update hit control");   // R7
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !ld_i) |=> ($stable(flags_o[BIT_SF:BIT_CF]) && $stable(flags_o[BIT_OF])))
    else $error("status moved");   // R7
  AST_ZF_SF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ld_i) |=> !(flags_o[BIT_ZF] && flags_o[BIT_SF]))
    else $error("zero and negative");   // R2
  AST_PARITY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ld_i) |=> flags_o[BIT_PF] == $past(^res_i[7:0]))
    else $error("parity");   // R4

endmodule

// File: tb/alu_flags_reg_tb.sv
module alu_flags_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [1:0]  wid = 2'd0;
  logic        sub = 1'b0;
  logic [31:0] a = '0, b = '0, res = '0;
  logic        cout = 1'b0;
  logic        ld = 1'b0;
  logic [15:0] ld_data = '0;
  logic [2:0]  set_s = '0, clr_s = '0;
  logic [15:0] flags;

  int total = 0;
  int bad = 0;
  logic [2:0] ctrl_m = '0;    // model of TF/IF/DF
  logic [15:0] stat_m = '0;   // model of status bits in place

  always #4 clk = ~clk;

  alu_flags_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .width_i(wid), .sub_i(sub),
    .a_i(a), .b_i(b), .res_i(res), .cout_i(cout), .ld_i(ld),
    .ld_data_i(ld_data), .set_i(set_s), .clr_i(clr_s), .flags_o(flags)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_m();
    return stat_m | {5'd0, ctrl_m, 8'd0};
  endfunction

  // applies one ALU op and checks flags one edge later
  task automatic do_op(input string req, input int n, input logic s,
                       input logic [31:0] x, input logic [31:0] y);
    logic [32:0] m, sum;
    logic [31:0] r;
    logic c, sa, sb, sr, of;
    m   = (n == 32) ? 33'h0_FFFF_FFFF : ((33'd1 << n) - 33'd1);
    sum = ({1'b0, x} & m) + (s ? ({1'b0, ~y} & m) : ({1'b0, y} & m)) + {32'd0, s};
    c   = sum[n];
    r   = sum[31:0] & m[31:0];
    if (n != 32) r = r | (32'hA5A5_A5A5 & ~m[31:0]);   // junk above width
    sa = x[n-1]; sb = y[n-1]; sr = r[n-1];
    of = (s ? (sa != sb) : (sa == sb)) && (sr != sa);
    stat_m = '0;
    stat_m[0]  = s ? ~c : c;
    stat_m[2]  = ^r[7:0];
    stat_m[4]  = x[4] ^ y[4] ^ r[4];
    stat_m[6]  = ((r & m[31:0]) == 0);
    stat_m[7]  = sr;
    stat_m[11] = of;
    @(negedge clk);
    upd = 1'b1; sub = s; a = x; b = y; res = r; cout = c;
    wid = (n == 8) ? 2'd0 : (n == 16) ? 2'd1 : 2'd2;
    @(posedge clk); #1;
    upd = 1'b0;
    chk(req, flags, word_m());
  endtask

  task automatic t_reset();
    chk("R10 reset", flags, 16'h0000);
  endtask

  task automatic t_byte_ops();
    do_op("R6 R1 add8 7F+1", 8, 1'b0, 32'h7F, 32'h01);
    do_op("R2 R5 add8 FF+1", 8, 1'b0, 32'hFF, 32'h01);
    do_op("R3 R4 add8 0F+01", 8, 1'b0, 32'h0F, 32'h01);
    do_op("R6 sub8 80-01", 8, 1'b1, 32'h80, 32'h01);
  endtask

  task automatic t_half_ops();
    do_op("R5 sub16 0-1 borrow", 16, 1'b1, 32'h0, 32'h1);
    do_op("R6 sub16 8000-1", 16, 1'b1, 32'h8000, 32'h1);
    do_op("R2 sub16 1234-1234", 16, 1'b1, 32'h1234, 32'h1234);
    do_op("R6 sub16 7FFF-FFFF", 16, 1'b1, 32'h7FFF, 32'hFFFF);
  endtask

  task automatic t_word_ops();
    do_op("R6 add32 7FFFFFFF+1", 32, 1'b0, 32'h7FFF_FFFF, 32'h1);
    do_op("R5 add32 FFFFFFFF+FFFFFFFF", 32, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op("R1 sub32 5-7", 32, 1'b1, 32'h5, 32'h7);
  endtask

  task automatic t_ctrl();
    @(negedge clk); set_s = 3'b101;
    @(posedge clk); #1; set_s = '0; ctrl_m = 3'b101;
    chk("R8 set DF TF", flags, word_m());
    @(negedge clk); set_s = 3'b010; clr_s = 3'b011;
    @(posedge clk); #1; set_s = '0; clr_s = '0; ctrl_m = 3'b100;
    chk("R8 clear wins", flags, word_m());
    do_op("R7 update keeps ctrl", 8, 1'b0, 32'h40, 32'h40);
  endtask

  task automatic t_hold();
    @(negedge clk); a = 32'hFFFF_FFFF; res = 32'h0; cout = ~cout; sub = ~sub;
    @(posedge clk); #1;
    chk("R7 no update holds", flags, word_m());
  endtask

  task automatic t_load();
    @(negedge clk); ld = 1'b1; ld_data = 16'hFFFF; upd = 1'b1; clr_s = 3'b111;
    res = 32'h0;
    @(posedge clk); #1; ld = 1'b0; upd = 1'b0; clr_s = '0;
    ctrl_m = 3'b111; stat_m = 16'h08D5;
    chk("R9 R10 load all ones", flags, 16'h0FD5);
    @(negedge clk); ld = 1'b1; ld_data = 16'hF02A; set_s = 3'b111;
    @(posedge clk); #1; ld = 1'b0; set_s = '0;
    ctrl_m = 3'b000; stat_m = 16'h0000;
    chk("R9 load masks and beats set", flags, 16'h0000);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_byte_ops();
    t_half_ops();
    t_word_ops();
    t_ctrl();
    t_hold();
    t_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule